// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirection Checker

This block decides, for a software interrupt raised while the processor runs virtual-8086 code, whether the vector goes to the real-mode style vector table (redirect) or to the protected-mode handler path (no redirect). It receives a vector number together with the cached task-segment descriptor fields (base, limit, present bit and 4-bit type). It then fetches the 16-bit I/O permission map offset from the task segment and one byte of the redirection bitmap that sits just below that map. Both fetches use a byte-wide memory read port.

The result is one of three mutually exclusive verdicts: redirect, no redirect, or a general-protection fault with error code zero. A fault is raised when the descriptor is unusable or when the bitmap byte lies past the segment limit. Dispatching the interrupt, pushing the stack frame, paging and segment translation belong to the surrounding logic. A request is accepted only while the block is idle. The verdict appears as a single-cycle pulse.

Top module: `swint_redir_check`

## Requirements
- R1: A request whose descriptor is not present, has a type field other than 9, or has a limit below 103 ends with a fault pulse in the cycle after acceptance, and no memory read is issued.
- R2: For a usable descriptor the block first reads the byte at base+0x66 and then the byte at base+0x67. It forms the I/O map offset little-endian, with the first byte as the low half.
- R3: The bitmap byte is read at base + (I/O offset − 0x20 + (vector >> 3)). The bit examined is bit vector[2:0] of that byte.
- R4: The byte offset (I/O offset − 0x20 + (vector >> 3)) is computed without wrap. If it is negative or greater than the task limit, the result is a fault and no bitmap read is issued.
- R5: A set bitmap bit gives the no-redirect verdict. A clear bit gives the redirect verdict.
- R6: `done` is high for exactly one cycle per request, and with it exactly one of `redirect`, `noRedirect`, `fault` is high. All three flags are low whenever `done` is low.
- R7: `ready` is high only in the idle state. A `reqValid` pulse while the block is busy is ignored and does not alter the running request. Vector and descriptor fields are captured at acceptance.
- R8: `memReq` is low while the block is idle. Once raised, it stays high with an unchanged `memAddr` until `memRvalid` returns the byte.
- R9: After reset the block is idle: `ready` high, and `done`, `memReq` and all verdict flags low.

Fault verdicts always carry an error code of zero, so no error-code port exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a check, taken only when `ready` is high |
| reqVector | input | 8 | Software interrupt vector |
| taskBase | input | 32 | Task-segment linear base |
| taskLimit | input | 32 | Task-segment byte limit |
| taskPresent | input | 1 | Descriptor present bit |
| taskType | input | 4 | Descriptor type field |
| ready | output | 1 | Idle, able to accept a request |
| memReq | output | 1 | Byte read request, held until answered |
| memAddr | output | 32 | Byte read address |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle verdict strobe |
| redirect | output | 1 | Vector goes to the real-mode style table |
| noRedirect | output | 1 | Vector goes to the protected-mode path |
| fault | output | 1 | General-protection fault, error code zero |

## Verification
The assertions cover the following on every cycle: the verdict pulse shape and the exclusivity of its flags, the held address during a stalled read, and the silent memory port while idle. They also check the immediate fault on a bad descriptor and the address of the first offset read. Only the bench scenarios can show that the bitmap address and bit index follow the offset arithmetic, and that the limit comparison falls exactly at its boundary. The same holds for negative offsets faulting, for the bit sense choosing redirect or no redirect, and for busy-time requests leaving the captured vector untouched. Those scenarios compare the verdict and the logged read addresses against a model.

// File: rtl/swint_redir_pkg.sv
package swint_redir_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OFF,
    ST_EVAL,
    ST_RD_MAP,
    ST_DONE
  } ctlState_t;

  typedef enum logic [1:0] {
    SEL_OFF_LO,
    SEL_OFF_HI,
    SEL_MAP
  } addrSel_t;

  typedef enum logic [1:0] {
    VERD_NONE,
    VERD_REDIR,
    VERD_KEEP,
    VERD_FAULT
  } verdict_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     latchReq;
    logic     capOffLo;
    logic     capOffHi;
    addrSel_t addrSel;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic descOkIn;
    logic mapOutOfRange;
    logic mapBit;
  } dpStatus_t;

endpackage

// File: rtl/swint_redir_datapath.sv
module swint_redir_datapath
  import swint_redir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_W      = 8,
  parameter int TYPE_W     = 4,
  parameter int TYPE_OK    = 9,
  parameter int MIN_LIMIT  = 103,
  parameter int OFFSET_LOC = 'h66,
  parameter int MAP_SPAN   = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [ADDR_W-1:0] taskBase,
  input  logic [ADDR_W-1:0] taskLimit,
  input  logic              taskPresent,
  input  logic [TYPE_W-1:0] taskType,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output dpStatus_t         status
);

  localparam int OFF_W  = 16;
  localparam int EXT_W  = OFF_W + 2;      // one spare bit plus a sign bit
  localparam int BIT_W  = 3;              // bit index inside a byte
  localparam int ZPAD_W = ADDR_W - (EXT_W - 1);

  logic [VEC_W-1:0]  vecQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] limitQ;
  logic [OFF_W-1:0]  ioOffQ;
  logic [EXT_W-1:0]  extOff;
  logic [ADDR_W-1:0] mapOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ   <= '0;
      baseQ  <= '0;
      limitQ <= '0;
      ioOffQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        vecQ   <= reqVector;
        baseQ  <= taskBase;
        limitQ <= taskLimit;
      end
      if (strobe.capOffLo) ioOffQ[7:0]  <= memRdata;
      if (strobe.capOffHi) ioOffQ[15:8] <= memRdata;
    end
  end

  // signed-safe offset: bit EXT_W-1 flags a negative result
  always_comb begin
    extOff = EXT_W'(ioOffQ) + EXT_W'(vecQ >> BIT_W) - EXT_W'(MAP_SPAN);
    mapOff = {{ZPAD_W{1'b0}}, extOff[EXT_W-2:0]};
  end

  always_comb begin
    unique case (strobe.addrSel)
      SEL_OFF_LO: memAddr = baseQ + ADDR_W'(OFFSET_LOC);
      SEL_OFF_HI: memAddr = baseQ + ADDR_W'(OFFSET_LOC + 1);
      default:    memAddr = baseQ + mapOff;
    endcase
  end

  always_comb begin
    status.descOkIn      = taskPresent && (taskType == TYPE_W'(TYPE_OK)) &&
                           (taskLimit >= ADDR_W'(MIN_LIMIT));
    status.mapOutOfRange = extOff[EXT_W-1] || (mapOff > limitQ);
    status.mapBit        = memRdata[vecQ[BIT_W-1:0]];
  end

endmodule

// File: rtl/swint_redir_control.sv
module swint_redir_control
  import swint_redir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRvalid,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      ready,
  output logic      done,
  output logic      redirect,
  output logic      noRedirect,
  output logic      fault
);

  ctlState_t stateQ, stateD;
  verdict_t  verdQ, verdD;
  logic      hiHalfQ, hiHalfD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      verdQ   <= VERD_NONE;
      hiHalfQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      verdQ   <= verdD;
      hiHalfQ <= hiHalfD;
    end
  end

  always_comb begin
    stateD   = stateQ;
    verdD    = verdQ;
    hiHalfD  = hiHalfQ;
    strobe   = '{latchReq: 1'b0, capOffLo: 1'b0, capOffHi: 1'b0,
                 addrSel: SEL_OFF_LO};
    memReq   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          hiHalfD         = 1'b0;
          if (status.descOkIn) begin
            stateD = ST_RD_OFF;
            verdD  = VERD_NONE;
          end else begin
            stateD = ST_DONE;
            verdD  = VERD_FAULT;
          end
        end
      end
      ST_RD_OFF: begin
        memReq         = 1'b1;
        strobe.addrSel = hiHalfQ ? SEL_OFF_HI : SEL_OFF_LO;
        if (memRvalid) begin
          if (hiHalfQ) begin
            strobe.capOffHi = 1'b1;
            stateD          = ST_EVAL;
          end else begin
            strobe.capOffLo = 1'b1;
            hiHalfD         = 1'b1;
          end
        end
      end
      ST_EVAL: begin
        strobe.addrSel = SEL_MAP;
        if (status.mapOutOfRange) begin
          verdD  = VERD_FAULT;
          stateD = ST_DONE;
        end else begin
          stateD = ST_RD_MAP;
        end
      end
      ST_RD_MAP: begin
        memReq         = 1'b1;
        strobe.addrSel = SEL_MAP;
        if (memRvalid) begin
          verdD  = status.mapBit ? VERD_KEEP : VERD_REDIR;
          stateD = ST_DONE;
        end
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  assign ready      = (stateQ == ST_IDLE);
  assign done       = (stateQ == ST_DONE);
  assign redirect   = done && (verdQ == VERD_REDIR);
  assign noRedirect = done && (verdQ == VERD_KEEP);
  assign fault      = done && (verdQ == VERD_FAULT);

endmodule

// File: rtl/swint_redir_check.sv
module swint_redir_check
  import swint_redir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_W      = 8,
  parameter int TYPE_W     = 4,
  parameter int TYPE_OK    = 9,
  parameter int MIN_LIMIT  = 103,
  parameter int OFFSET_LOC = 'h66,
  parameter int MAP_SPAN   = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [ADDR_W-1:0] taskBase,
  input  logic [ADDR_W-1:0] taskLimit,
  input  logic              taskPresent,
  input  logic [TYPE_W-1:0] taskType,
  output logic              ready,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRvalid,
  input  logic [7:0]        memRdata,
  output logic              done,
  output logic              redirect,
  output logic              noRedirect,
  output logic              fault
);

  dpStrobe_t strobe;
  dpStatus_t status;

  swint_redir_datapath #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .TYPE_W(TYPE_W), .TYPE_OK(TYPE_OK),
    .MIN_LIMIT(MIN_LIMIT), .OFFSET_LOC(OFFSET_LOC), .MAP_SPAN(MAP_SPAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVector(reqVector),
    .taskBase(taskBase), .taskLimit(taskLimit), .taskPresent(taskPresent),
    .taskType(taskType), .memRdata(memRdata), .memAddr(memAddr),
    .status(status)
  );

  swint_redir_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRvalid(memRvalid),
    .status(status), .strobe(strobe), .memReq(memReq), .ready(ready),
    .done(done), .redirect(redirect), .noRedirect(noRedirect), .fault(fault)
  );

endmodule

// File: rtl/swint_redir_check_sva.sv
module swint_redir_check_sva #(
  parameter int ADDR_W     = 32,
  parameter int TYPE_W     = 4,
  parameter int TYPE_OK    = 9,
  parameter int MIN_LIMIT  = 103,
  parameter int OFFSET_LOC = 'h66
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] taskBase,
  input logic [ADDR_W-1:0] taskLimit,
  input logic              taskPresent,
  input logic [TYPE_W-1:0] taskType,
  input logic              ready,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRvalid,
  input logic              done,
  input logic              redirect,
  input logic              noRedirect,
  input logic              fault
);

  logic descGood;
  assign descGood = taskPresent && (taskType == TYPE_W'(TYPE_OK)) &&
                    (taskLimit >= ADDR_W'(MIN_LIMIT));

  assert_bad_desc_fault_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid && !descGood) |=> (done && fault));

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid && descGood) |=>
      (memReq && memAddr == $past(taskBase) + ADDR_W'(OFFSET_LOC)));

  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({redirect, noRedirect, fault}) == 1));

  assert_quiet_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(redirect || noRedirect || fault));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !done) |=> !ready);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> (memReq && $stable(memAddr)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !memReq);

endmodule

bind swint_redir_check swint_redir_check_sva #(
  .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .TYPE_OK(TYPE_OK),
  .MIN_LIMIT(MIN_LIMIT), .OFFSET_LOC(OFFSET_LOC)
) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .taskBase(taskBase),
  .taskLimit(taskLimit), .taskPresent(taskPresent), .taskType(taskType),
  .ready(ready), .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid),
  .done(done), .redirect(redirect), .noRedirect(noRedirect), .fault(fault)
);

// File: tb/swint_redir_check_test.sv
module swint_redir_check_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic [31:0] taskBase = '0;
  logic [31:0] taskLimit = '0;
  logic        taskPresent = 1'b0;
  logic [3:0]  taskType = '0;
  logic        ready, memReq, done, redirect, noRedirect, fault;
  logic [31:0] memAddr;
  logic        memRvalid = 1'b0;
  logic [7:0]  memRdata = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // memory model state
  logic [31:0] curBase = '0;
  logic [15:0] curOff = '0;
  int          waitCnt = 0;
  int          readCount = 0;
  logic [31:0] hist0 = '0, hist1 = '0, hist2 = '0;

  always #2.5 clk = ~clk;

  swint_redir_check uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .taskBase(taskBase), .taskLimit(taskLimit), .taskPresent(taskPresent),
    .taskType(taskType), .ready(ready), .memReq(memReq), .memAddr(memAddr),
    .memRvalid(memRvalid), .memRdata(memRdata), .done(done),
    .redirect(redirect), .noRedirect(noRedirect), .fault(fault)
  );

  function automatic logic [7:0] memByte(logic [31:0] a);
    logic [31:0] h;
    if (a == curBase + 32'h66) return curOff[7:0];
    if (a == curBase + 32'h67) return curOff[15:8];
    h = (a ^ 32'h5A17C3E1) * 32'h9E3779B1;
    return h[23:16];
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRvalid) begin
      memRvalid <= 1'b0;
    end else if (memReq) begin
      if (waitCnt > 0) begin
        waitCnt <= waitCnt - 1;
      end else begin
        memRvalid <= 1'b1;
        memRdata  <= memByte(memAddr);
        readCount <= readCount + 1;
        hist2 <= hist1; hist1 <= hist0; hist0 <= memAddr;
        waitCnt <= int'($urandom % 3);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // verdict code: 1 redirect, 2 no redirect, 3 fault
  task automatic runOne(input logic [31:0] base, input logic [31:0] limit,
                        input bit pres, input logic [3:0] typ,
                        input logic [7:0] vec, input logic [15:0] off,
                        input bit glitch);
    int expV, expReads, startReads, gotV, t;
    longint ext;
    logic [31:0] mapAddr;
    logic [7:0] mb;
    curBase = base; curOff = off;
    ext = longint'(off) - 32 + longint'(vec >> 3);
    mapAddr = base + 32'(ext);
    expReads = 0;
    if (!pres || typ != 4'd9 || limit < 32'd103) begin
      expV = 3;
    end else if (ext < 0 || ext > longint'(limit)) begin
      expV = 3; expReads = 2;
    end else begin
      mb = memByte(mapAddr);
      expV = mb[vec[2:0]] ? 2 : 1;
      expReads = 3;
    end
    @(negedge clk);
    startReads = readCount;
    taskBase = base; taskLimit = limit; taskPresent = pres;
    taskType = typ; reqVector = vec; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (glitch && !done) begin
      // R7: busy-time request with other fields must be ignored
      reqVector = ~vec; taskBase = base ^ 32'h00F0_0F00; taskPresent = 1'b0;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    t = 0;
    while (!done && t < 100) begin
      @(negedge clk);
      t++;
    end
    gotV = redirect ? 1 : noRedirect ? 2 : fault ? 3 : 0;
    check(done, "R6", "done seen", 32'(done), 32'd1);
    check(gotV == expV, glitch ? "R7" : (expV == 3 ? "R4" : "R5"),
          "verdict", 32'(gotV), 32'(expV));
    check(readCount - startReads == expReads, expReads == 0 ? "R1" : "R4",
          "read count", 32'(readCount - startReads), 32'(expReads));
    if (expReads == 2) begin
      check(hist1 == base + 32'h66 && hist0 == base + 32'h67, "R2",
            "offset addrs", hist1, base + 32'h66);
    end else if (expReads == 3) begin
      check(hist2 == base + 32'h66 && hist1 == base + 32'h67, "R2",
            "offset addrs", hist2, base + 32'h66);
      check(hist0 == mapAddr, "R3", "bitmap addr", hist0, mapAddr);
    end
    @(negedge clk);
    check(!done && ready && !memReq, "R8", "idle after done",
          {29'd0, done, ready, memReq}, 32'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(ready && !done && !memReq && !redirect && !noRedirect && !fault,
          "R9", "reset outputs",
          {26'd0, ready, done, memReq, redirect, noRedirect, fault}, 32'h20);
    rstN = 1'b1;
    void'($urandom(32'd1234));
    // R1 descriptor corner cases
    runOne(32'h0001_0000, 32'd500, 1'b0, 4'd9, 8'h21, 16'h0080, 1'b0);
    runOne(32'h0001_0000, 32'd500, 1'b1, 4'd11, 8'h21, 16'h0080, 1'b0);
    runOne(32'h0001_0000, 32'd102, 1'b1, 4'd9, 8'h21, 16'h0040, 1'b0);
    runOne(32'h0001_0000, 32'd103, 1'b1, 4'd9, 8'h00, 16'h0040, 1'b0);
    // R4 limit boundary: offset 0x60+0x1F = 0x7F
    runOne(32'h0002_0000, 32'h7F, 1'b1, 4'd9, 8'hFF, 16'h0080, 1'b0);
    runOne(32'h0002_0000, 32'h7E, 1'b1, 4'd9, 8'hFF, 16'h0080, 1'b0);
    // R4 negative offset, and exactly zero
    runOne(32'h0003_0000, 32'h1000, 1'b1, 4'd9, 8'h07, 16'h001F, 1'b0);
    runOne(32'h0003_0000, 32'h1000, 1'b1, 4'd9, 8'h07, 16'h0020, 1'b0);
    // R3 high offset
    runOne(32'hFFFF_F000, 32'hFFFF_FFFF, 1'b1, 4'd9, 8'hF3, 16'hFFFF, 1'b0);
    // R7 busy requests ignored
    runOne(32'h0004_0000, 32'h2000, 1'b1, 4'd9, 8'h55, 16'h0100, 1'b1);
    runOne(32'h0004_0000, 32'd500, 1'b0, 4'd9, 8'h55, 16'h0100, 1'b1);
    // random mix, R5 both verdicts
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b, l;
      logic [15:0] o;
      b = $urandom;
      l = 32'd90 + ($urandom % 32'h600);
      o = 16'($urandom % (l + 96));
      runOne(b, l, ($urandom % 10) != 0, (($urandom % 10) != 0) ? 4'd9 : 4'($urandom),
             8'($urandom), o, ($urandom % 8) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule